// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Decoder

This block is the transaction sequencer that sits between a serial byte receiver and the register bank of a four-channel digital potentiometer. The receiver hands it pulse-level events: start and end of a chip-select frame, each completed byte, and each serial clock pulse together with the data-in level. The decoder qualifies the first byte of a frame as an identification byte, interprets the second byte as a command, and then drives single-cycle requests towards the register bank. For readback it also hands a byte to the serial transmitter.

Commands fall into a few shapes. Some finish with the command byte. Some take one more byte, either a write payload or a readback. One is an open-ended stepping mode in which every later clock pulse nudges a wiper up or down. Requests that change non-volatile storage are not issued as soon as they are decoded. They are parked until the frame ends and issued only then, so a frame that is abandoned early leaves the storage alone.

Top module: `potcmd_decoder`

## Requirements
- R1: After `cs_fall`, the first byte on `rx_valid` is accepted only if bits [7:4] are 0101, bits [3:2] are 00 and bits [1:0] equal `dev_addr`. Any other value suppresses every `req_valid` and `tx_valid` until the next `cs_fall`.
- R2: In the command byte, bits [7:4] hold the opcode, bits [3:2] the register select and bits [1:0] the channel select. Every request carries these two selects on `req_reg` and `req_pot`. `req_data` is zero except for writes. `req_kind` takes only the codes 1 to 10.
- R3: Opcode 1101 (data register to wiper) and opcode 0001 (all channels, data register to wiper) each give one request in the cycle after the command byte, with kind 5 and kind 7.
- R4: Opcode 1001 (read wiper) and opcode 1011 (read data register) give a request with kind 1 or kind 3 in the cycle after the command byte. In the next cycle `tx_valid` pulses, and `tx_byte` holds the `rd_data` value seen during the request cycle.
- R5: Opcode 0101 (status) pulses `tx_valid` in the cycle after the command byte. `tx_byte` is all zero except bit 0, which holds the `wip` level sampled at that byte.
- R6: Opcode 1010 (write wiper) waits for a third byte, then issues kind 2 in the following cycle with `req_data` equal to that byte.
- R7: The non-volatile commands are opcode 1100 (write data register, kind 4, payload from the third byte), opcode 1110 (wiper to data register, kind 6) and opcode 1000 (all wipers to data registers, kind 8). Their request appears only in the cycle after `cs_rise`, never earlier.
- R8: If `cs_rise` comes before the third byte of a write, no request is made.
- R9: After opcode 0010, each `sck_pulse` gives a request in the next cycle: kind 9 when `si_level` is high, kind 10 when it is low. This continues until `cs_rise`. Pulses that belong to the first two bytes never step.
- R10: Any opcode not listed above gives no request and no readback for the rest of the frame.
- R11: Bytes after a command has completed are ignored, and so are bytes and pulses that arrive while the chip is deselected. `cs_rise` always ends the frame.
- R12: While `rst_n` is low, `req_valid` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 2 | Strapped device address |
| cs_fall | input | 1 | Pulse: chip select asserted, frame begins |
| cs_rise | input | 1 | Pulse: chip select released, frame ends |
| rx_valid | input | 1 | Pulse: a complete byte is on rx_byte |
| rx_byte | input | 8 | Received byte, bit 7 first on the wire |
| sck_pulse | input | 1 | Pulse per serial clock bit |
| si_level | input | 1 | Serial data-in level at that pulse |
| wip | input | 1 | Non-volatile write in progress |
| rd_data | input | 8 | Register bank read answer during a read request |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 4 | Request code 1..10 |
| req_pot | output | 2 | Channel select |
| req_reg | output | 2 | Register select |
| req_data | output | 8 | Write payload |
| tx_valid | output | 1 | One-cycle strobe: byte to transmit |
| tx_byte | output | 8 | Byte for the serial transmitter |

## Verification
The hardest case to reach is the stepping mode. There, byte-complete strobes and clock pulses keep arriving together, and the pulse that completes the command byte must not count as a step. The stimulus drives every byte bit by bit with a pulse per bit, so the coincident edge is exercised. It then runs mixed up and down pulses and passes more than eight of them, so a stray byte strobe falls inside the stepping run. Frames abandoned before the payload, and non-volatile commands followed by a delayed release, check that parked requests appear only at the frame end.

// File: rtl/potcmd_pkg.sv
// Shared types for the potentiometer command decoder.
package potcmd_pkg;

    // Request codes seen by the register bank (values are part of the interface).
    typedef enum logic [3:0] {
        K_NONE      = 4'd0,
        K_RD_WIPER  = 4'd1,
        K_WR_WIPER  = 4'd2,
        K_RD_DREG   = 4'd3,
        K_WR_DREG   = 4'd4,
        K_XFER_D2W  = 4'd5,
        K_STORE_W2D = 4'd6,
        K_GXFER     = 4'd7,
        K_GSTORE    = 4'd8,
        K_STEP_UP   = 4'd9,
        K_STEP_DN   = 4'd10
    } req_kind_e;

    // Sequence shape of a decoded command.
    typedef enum logic [2:0] {
        F_BAD, F_NOW, F_HOLD, F_READ, F_WR_NOW, F_WR_HOLD, F_STATUS, F_STEP
    } flow_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ID, S_INSTR, S_DATA, S_STEP, S_SINK
    } seq_e;

    typedef struct packed {
        req_kind_e kind;
        flow_e     flow;
    } op_info_t;

endpackage

// File: rtl/potcmd_id_match.sv
// Identification byte checker.
// Purpose: flags whether a byte carries the fixed type code, zero padding and
//          the strapped device address.
// Assumes: BYTE_W >= TYPE_W + ADDR_W + 1; purely combinational.
module potcmd_id_match #(
    parameter int          BYTE_W    = 8,
    parameter int          TYPE_W    = 4,
    parameter int          ADDR_W    = 2,
    parameter logic [3:0]  TYPE_CODE = 4'b0101
) (
    input  logic [BYTE_W-1:0] id_byte,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              hit
);
    localparam int PAD_W = BYTE_W - TYPE_W - ADDR_W;

    // Compare all three fields of the identification byte.
    always_comb begin
        hit = (id_byte[BYTE_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0])
           && (id_byte[ADDR_W +: PAD_W] == '0)
           && (id_byte[ADDR_W-1:0] == dev_addr);
    end
endmodule

// File: rtl/potcmd_op_decode.sv
// Opcode classifier.
// Purpose: maps the 4-bit opcode to a request code and a sequence shape.
// Assumes: unlisted opcodes are reported as F_BAD; purely combinational.
module potcmd_op_decode
    import potcmd_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic [OP_W-1:0] opcode,
    output op_info_t        info
);
    // Table of supported commands.
    always_comb begin
        info = '{kind: K_NONE, flow: F_BAD};
        case (opcode)
            4'b1001: info = '{kind: K_RD_WIPER,  flow: F_READ};
            4'b1011: info = '{kind: K_RD_DREG,   flow: F_READ};
            4'b1010: info = '{kind: K_WR_WIPER,  flow: F_WR_NOW};
            4'b1100: info = '{kind: K_WR_DREG,   flow: F_WR_HOLD};
            4'b1101: info = '{kind: K_XFER_D2W,  flow: F_NOW};
            4'b0001: info = '{kind: K_GXFER,     flow: F_NOW};
            4'b1110: info = '{kind: K_STORE_W2D, flow: F_HOLD};
            4'b1000: info = '{kind: K_GSTORE,    flow: F_HOLD};
            4'b0010: info = '{kind: K_NONE,      flow: F_STEP};
            4'b0101: info = '{kind: K_NONE,      flow: F_STATUS};
            default: info = '{kind: K_NONE,      flow: F_BAD};
        endcase
    end
endmodule

// File: rtl/potcmd_commit_hold.sv
// Parking slot for one non-volatile request.
// Purpose: holds a decoded store until the frame ends, then hands it out once.
// Assumes: at most one arm per frame; fire and flush are single-cycle pulses.
module potcmd_commit_hold
    import potcmd_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  req_kind_e         arm_kind,
    input  logic [SEL_W-1:0]  arm_pot,
    input  logic [SEL_W-1:0]  arm_reg,
    input  logic [BYTE_W-1:0] arm_data,
    input  logic              fire,
    input  logic              flush,
    output logic              pend_valid,
    output req_kind_e         pend_kind,
    output logic [SEL_W-1:0]  pend_pot,
    output logic [SEL_W-1:0]  pend_reg,
    output logic [BYTE_W-1:0] pend_data
);
    // Capture on arm, drop on frame end or frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_kind  <= K_NONE;
            pend_pot   <= '0;
            pend_reg   <= '0;
            pend_data  <= '0;
        end else if (fire || flush) begin
            pend_valid <= 1'b0;
        end else if (arm) begin
            pend_valid <= 1'b1;
            pend_kind  <= arm_kind;
            pend_pot   <= arm_pot;
            pend_reg   <= arm_reg;
            pend_data  <= arm_data;
        end
    end

    // R7: a frame parks at most one store.
    p_single_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !pend_valid);
endmodule

// File: rtl/potcmd_decoder.sv
// Potentiometer serial command decoder (top).
// Purpose: qualifies the identification byte, decodes the command byte and
//          drives one-cycle requests to the register bank and readback bytes
//          to the transmitter; non-volatile requests wait for frame end.
// Assumes: cs_fall, cs_rise, rx_valid and sck_pulse are single-cycle pulses;
//          cs_rise never coincides with rx_valid; rd_data answers a read
//          request combinationally in the request cycle.
module potcmd_decoder
    import potcmd_pkg::*;
#(
    parameter int         BYTE_W    = 8,
    parameter int         OP_W      = 4,
    parameter int         SEL_W     = 2,
    parameter int         TYPE_W    = 4,
    parameter logic [3:0] TYPE_CODE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dev_addr,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              sck_pulse,
    input  logic              si_level,
    input  logic              wip,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              req_valid,
    output logic [3:0]        req_kind,
    output logic [SEL_W-1:0]  req_pot,
    output logic [SEL_W-1:0]  req_reg,
    output logic [BYTE_W-1:0] req_data,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    localparam int REG_LSB = SEL_W;

    seq_e              st;
    op_info_t          op;
    logic              id_hit;
    flow_e             hold_flow;
    req_kind_e         hold_kind;
    logic [SEL_W-1:0]  hold_pot, hold_reg;
    logic              arm;
    req_kind_e         arm_kind;
    logic [SEL_W-1:0]  arm_pot, arm_reg;
    logic [BYTE_W-1:0] arm_data;
    logic              pend_valid;
    req_kind_e         pend_kind;
    logic [SEL_W-1:0]  pend_pot, pend_reg;
    logic [BYTE_W-1:0] pend_data;
    logic              rd_pending;

    wire [OP_W-1:0]  f_op  = rx_byte[BYTE_W-1 -: OP_W];
    wire [SEL_W-1:0] f_reg = rx_byte[REG_LSB +: SEL_W];
    wire [SEL_W-1:0] f_pot = rx_byte[SEL_W-1:0];

    potcmd_id_match #(.BYTE_W(BYTE_W), .TYPE_W(TYPE_W), .ADDR_W(SEL_W),
                      .TYPE_CODE(TYPE_CODE))
        i_id (.id_byte(rx_byte), .dev_addr(dev_addr), .hit(id_hit));

    potcmd_op_decode #(.OP_W(OP_W)) i_op (.opcode(f_op), .info(op));

    // Decide whether this cycle parks a non-volatile request.
    always_comb begin
        arm      = 1'b0;
        arm_kind = op.kind;
        arm_pot  = f_pot;
        arm_reg  = f_reg;
        arm_data = '0;
        if (!cs_rise && !cs_fall && rx_valid) begin
            if (st == S_INSTR && op.flow == F_HOLD) begin
                arm = 1'b1;
            end else if (st == S_DATA && hold_flow == F_WR_HOLD) begin
                arm      = 1'b1;
                arm_kind = hold_kind;
                arm_pot  = hold_pot;
                arm_reg  = hold_reg;
                arm_data = rx_byte;
            end
        end
    end

    potcmd_commit_hold #(.SEL_W(SEL_W), .BYTE_W(BYTE_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_kind(arm_kind),
        .arm_pot(arm_pot), .arm_reg(arm_reg), .arm_data(arm_data),
        .fire(cs_rise), .flush(cs_fall), .pend_valid(pend_valid),
        .pend_kind(pend_kind), .pend_pot(pend_pot), .pend_reg(pend_reg),
        .pend_data(pend_data));

    assign rd_pending = req_valid && (req_kind == K_RD_WIPER || req_kind == K_RD_DREG);

    // Sequencer, request strobe and readback strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            req_valid <= 1'b0;
            req_kind  <= K_NONE;
            req_pot   <= '0;
            req_reg   <= '0;
            req_data  <= '0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
            hold_flow <= F_BAD;
            hold_kind <= K_NONE;
            hold_pot  <= '0;
            hold_reg  <= '0;
        end else begin
            req_valid <= 1'b0;
            tx_valid  <= 1'b0;
            if (rd_pending) begin
                tx_valid <= 1'b1;
                tx_byte  <= rd_data;
            end
            if (cs_rise) begin
                st <= S_IDLE;
                if (pend_valid) begin
                    req_valid <= 1'b1;
                    req_kind  <= pend_kind;
                    req_pot   <= pend_pot;
                    req_reg   <= pend_reg;
                    req_data  <= pend_data;
                end
            end else if (cs_fall) begin
                st <= S_ID;
            end else begin
                case (st)
                    S_ID: if (rx_valid) st <= id_hit ? S_INSTR : S_SINK;
                    S_INSTR: if (rx_valid) begin
                        hold_flow <= op.flow;
                        hold_kind <= op.kind;
                        hold_pot  <= f_pot;
                        hold_reg  <= f_reg;
                        st        <= S_SINK;
                        case (op.flow)
                            F_NOW, F_READ: begin
                                req_valid <= 1'b1;
                                req_kind  <= op.kind;
                                req_pot   <= f_pot;
                                req_reg   <= f_reg;
                                req_data  <= '0;
                            end
                            F_STATUS: begin
                                tx_valid <= 1'b1;
                                tx_byte  <= {{(BYTE_W-1){1'b0}}, wip};
                            end
                            F_WR_NOW, F_WR_HOLD: st <= S_DATA;
                            F_STEP:              st <= S_STEP;
                            default: ;
                        endcase
                    end
                    S_DATA: if (rx_valid) begin
                        st <= S_SINK;
                        if (hold_flow == F_WR_NOW) begin
                            req_valid <= 1'b1;
                            req_kind  <= hold_kind;
                            req_pot   <= hold_pot;
                            req_reg   <= hold_reg;
                            req_data  <= rx_byte;
                        end
                    end
                    S_STEP: if (sck_pulse) begin
                        req_valid <= 1'b1;
                        req_kind  <= si_level ? K_STEP_UP : K_STEP_DN;
                        req_pot   <= hold_pot;
                        req_reg   <= hold_reg;
                        req_data  <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: every read request is answered by a readback strobe.
    p_read_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pending |=> tx_valid);

    // R7: non-volatile requests only follow the end of a frame.
    p_nv_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == K_WR_DREG || req_kind == K_STORE_W2D ||
                       req_kind == K_GSTORE)) |-> $past(cs_rise));

    // R9: each step request follows a serial clock pulse.
    p_step_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == K_STEP_UP || req_kind == K_STEP_DN))
        |-> $past(sck_pulse));

    // R2: request codes stay inside the defined range.
    p_kind_defined_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind != K_NONE && req_kind <= K_STEP_DN));

    // R11: frame end brings no readback unless a read was already in flight.
    p_quiet_after_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !rd_pending) |=> !tx_valid);
endmodule

// File: tb/test_potcmd_decoder.sv
module test_potcmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dev_addr = 2'b10;
    logic       cs_fall = 0, cs_rise = 0, rx_valid = 0, sck_pulse = 0, si_level = 0, wip = 0;
    logic [7:0] rx_byte = 0;
    logic [7:0] rd_data;
    logic       req_valid, tx_valid;
    logic [3:0] req_kind;
    logic [1:0] req_pot, req_reg;
    logic [7:0] req_data, tx_byte;

    always #2 clk = ~clk;   // 250 MHz

    // Bench-side register bank answer.
    assign rd_data = {req_pot, req_reg, req_kind} ^ 8'h5A;

    potcmd_decoder i_potcmd_decoder (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .sck_pulse(sck_pulse), .si_level(si_level), .wip(wip), .rd_data(rd_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_pot(req_pot),
        .req_reg(req_reg), .req_data(req_data), .tx_valid(tx_valid), .tx_byte(tx_byte));

    int    n_cmp = 0, n_bad = 0, wd = 0;
    bit    started = 0, done = 0;
    string tag = "R12";

    // Reference model state.
    int         mode = 0;       // 0 idle, 1 id, 2 command, 3 payload, 4 stepping, 9 ignore
    int         wkind = 0;
    logic [1:0] mpot, mreg;
    bit         pend = 0;
    logic [3:0] p_kind; logic [1:0] p_pot, p_reg; logic [7:0] p_data;
    bit         e_req = 0, e_tx = 0;
    logic [3:0] e_kind = 0; logic [1:0] e_pot = 0, e_reg = 0;
    logic [7:0] e_data = 0, e_txb = 0;

    always @(posedge clk) begin
        bit n_req, n_tx;
        started = 1;
        n_req = 0; n_tx = 0;
        if (!rst_n) begin
            mode = 0; pend = 0; e_req = 0; e_tx = 0;
        end else begin
            if (e_req && (e_kind == 1 || e_kind == 3)) begin
                n_tx = 1; e_txb = {e_pot, e_reg, e_kind} ^ 8'h5A;
            end
            if (cs_rise) begin
                mode = 0;
                if (pend) begin
                    n_req = 1; e_kind = p_kind; e_pot = p_pot; e_reg = p_reg; e_data = p_data;
                end
                pend = 0;
            end else if (cs_fall) begin
                mode = 1; pend = 0;
            end else if (mode == 1 && rx_valid) begin
                mode = (rx_byte == {4'b0101, 2'b00, dev_addr}) ? 2 : 9;
            end else if (mode == 2 && rx_valid) begin
                mpot = rx_byte[1:0]; mreg = rx_byte[3:2]; mode = 9;
                case (rx_byte[7:4])
                    4'b1001: begin n_req = 1; e_kind = 1; end
                    4'b1011: begin n_req = 1; e_kind = 3; end
                    4'b1101: begin n_req = 1; e_kind = 5; end
                    4'b0001: begin n_req = 1; e_kind = 7; end
                    4'b1110: begin pend = 1; p_kind = 6; p_pot = mpot; p_reg = mreg; p_data = 0; end
                    4'b1000: begin pend = 1; p_kind = 8; p_pot = mpot; p_reg = mreg; p_data = 0; end
                    4'b1010: begin mode = 3; wkind = 2; end
                    4'b1100: begin mode = 3; wkind = 4; end
                    4'b0101: begin n_tx = 1; e_txb = {7'd0, wip}; end
                    4'b0010: mode = 4;
                    default: mode = 9;
                endcase
                if (n_req) begin e_pot = mpot; e_reg = mreg; e_data = 0; end
            end else if (mode == 3 && rx_valid) begin
                mode = 9;
                if (wkind == 2) begin
                    n_req = 1; e_kind = 2; e_pot = mpot; e_reg = mreg; e_data = rx_byte;
                end else begin
                    pend = 1; p_kind = 4; p_pot = mpot; p_reg = mreg; p_data = rx_byte;
                end
            end else if (mode == 4 && sck_pulse) begin
                n_req = 1; e_kind = si_level ? 4'd9 : 4'd10;
                e_pot = mpot; e_reg = mreg; e_data = 0;
            end
            e_req = n_req; e_tx = n_tx;
        end
    end

    // Compare against the model on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit ok;
            ok = (req_valid === e_req) && (tx_valid === e_tx);
            if (ok && e_req)
                ok = (req_kind === e_kind) && (req_pot === e_pot) &&
                     (req_reg === e_reg) && (req_data === e_data);
            if (ok && e_tx) ok = (tx_byte === e_txb);
            n_cmp++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s: got req=%b k=%0d p=%0d r=%0d d=%h tx=%b b=%h exp req=%b k=%0d p=%0d r=%0d d=%h tx=%b b=%h",
                    tag, req_valid, req_kind, req_pot, req_reg, req_data, tx_valid, tx_byte,
                    e_req, e_kind, e_pot, e_reg, e_data, e_tx, e_txb);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1; n_bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc(input logic f, input logic r, input logic v, input logic [7:0] b,
                       input logic s, input logic i);
        @(negedge clk);
        cs_fall = f; cs_rise = r; rx_valid = v; rx_byte = b; sck_pulse = s; si_level = i;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 8'h00, 0, 0);
    endtask

    task automatic send(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            cyc(0, 0, k == 0, b, 1, b[k]);
            cyc(0, 0, 0, 8'h00, 0, 0);
        end
    endtask

    task automatic open_frame();  cyc(1, 0, 0, 0, 0, 0); idle(1); endtask
    task automatic close_frame(); cyc(0, 1, 0, 0, 0, 0); idle(3); endtask

    localparam logic [7:0] ID_OK = 8'b0101_0010;

    initial begin
        // R12: outputs quiet in reset.
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        tag = "R4"; // read wiper, channel 2
        open_frame(); send(ID_OK); send(8'b1001_0010); send(8'hFF); idle(2); close_frame();
        tag = "R4"; // read data register 3 of channel 1
        open_frame(); send(ID_OK); send(8'b1011_1101); send(8'h00); close_frame();

        tag = "R1"; // wrong type code, then a write that must be dropped
        open_frame(); send(8'b0110_0010); send(8'b1010_0001); send(8'h33); close_frame();
        tag = "R1"; // wrong address bits
        open_frame(); send(8'b0101_0001); send(8'b1101_0000); close_frame();
        tag = "R1"; // padding bits set
        open_frame(); send(8'b0101_0110); send(8'b0001_0000); close_frame();

        tag = "R5";
        wip = 1'b1;
        open_frame(); send(ID_OK); send(8'b0101_0001); send(8'h00); close_frame();
        wip = 1'b0;
        open_frame(); send(ID_OK); send(8'b0101_0001); close_frame();

        tag = "R3";
        open_frame(); send(ID_OK); send(8'b1101_1011); close_frame();
        open_frame(); send(ID_OK); send(8'b0001_0100); close_frame();

        tag = "R6";
        open_frame(); send(ID_OK); send(8'b1010_0011); send(8'hC5); close_frame();

        tag = "R7"; // parked writes and stores; long gap before release
        open_frame(); send(ID_OK); send(8'b1100_0110); send(8'h9E); idle(10); close_frame();
        open_frame(); send(ID_OK); send(8'b1110_1001); idle(6); close_frame();
        open_frame(); send(ID_OK); send(8'b1000_1100); close_frame();

        tag = "R8"; // payload cut short
        open_frame(); send(ID_OK); send(8'b1100_0001);
        for (int k = 0; k < 5; k++) begin cyc(0, 0, 0, 0, 1, 1); idle(1); end
        close_frame();
        open_frame(); send(ID_OK); send(8'b1010_0010); close_frame();

        tag = "R9"; // stepping, more than one byte of pulses
        open_frame(); send(ID_OK); send(8'b0010_0011);
        for (int k = 0; k < 11; k++) begin
            cyc(0, 0, k == 7, 8'hA5, 1, (k % 3) != 0);
            idle(1);
        end
        close_frame();
        idle(1); cyc(0, 0, 0, 0, 1, 1); idle(2); // after release: no step

        tag = "R10";
        open_frame(); send(ID_OK); send(8'b0000_0101); send(8'h11); close_frame();
        open_frame(); send(ID_OK); send(8'b1111_0000); close_frame();
        open_frame(); send(ID_OK); send(8'b0011_0010); send(8'h22); close_frame();

        tag = "R11"; // trailing bytes, then traffic while deselected
        open_frame(); send(ID_OK); send(8'b1101_0001); send(8'b1101_0010); send(ID_OK); close_frame();
        send(ID_OK); send(8'b1001_0000); send(8'h5C); idle(2);

        tag = "R2"; // field placement on another channel/register
        open_frame(); send(ID_OK); send(8'b1101_0110); close_frame();

        tag = "R12"; // reset in mid-frame
        open_frame(); send(ID_OK);
        @(negedge clk) rst_n = 1'b0;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        send(8'b1101_0000); idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule